// File: doc/BRIEF.md
# SDRAM Power-Up Initialization and Self-Refresh Sequencer

This block is the command sequencer of an SDRAM controller. From reset it holds the command pins at NOP until the power-up wait has passed. The wait is a parameter in microseconds, scaled by the clock frequency in MHz. Software first arms the sequencer through an 8-bit control register. A dummy write into SDRAM space then starts the bring-up series: one precharge of all banks, a fixed number of auto refreshes, and one mode-register load. The mode word is driven on the address bus, so every device on the bus is programmed in the same cycle. Once the series ends, the active flag is set and normal accesses may begin.

Later, a sleep request lets the access in progress drain. The block then issues precharge-all, at least one NOP, and a refresh with clock enable dropped, which leaves the devices in self-refresh. Clearing the request raises clock enable, waits an exit time, and returns to the ready state. Command spacings are parameters in clock cycles: precharge period T_RP, refresh cycle T_RC, mode-set delay T_MRD and self-refresh exit T_XSR. Each must be at least 2.

States: PWRUP (power-up wait), IDLE (waiting for arm and dummy write), PRE and PRE_WAIT, REF and REF_WAIT, LMR and LMR_WAIT, READY, DRAIN, SLP_PRE, SLP_GAP, SLP_REF, SLEEP, WAKE. Transitions:
- PWRUP to IDLE when the wait expires.
- IDLE to PRE on a dummy write while armed.
- PRE to PRE_WAIT, and PRE_WAIT to REF after T_RP.
- REF to REF_WAIT, then REF_WAIT back to REF after T_RC while refreshes remain, or REF_WAIT to LMR after T_RC once all are done.
- LMR to LMR_WAIT, and LMR_WAIT to READY after T_MRD. This last transition sets the active flag.
- READY to DRAIN on a sleep request, and DRAIN to SLP_PRE once the access path is idle.
- SLP_PRE to SLP_GAP, SLP_GAP to SLP_REF after T_RP, and SLP_REF to SLEEP.
- SLEEP to WAKE when the request clears, and WAKE to READY after T_XSR.

Top module: `sdram_seq`

## Requirements
- R1: Power-up lasts CLK_MHZ*PWRUP_US cycles after reset (25000 by default). No command other than NOP appears in that time, and a dummy write during it is ignored, even in its last cycle.
- R2: The bring-up starts only from IDLE on a mem_wr pulse while control bit 0 (arm) is 1. A mem_wr pulse with bit 0 clear issues no command and leaves the active flag clear. The first command follows the dummy write cycle by one cycle.
- R3: The bring-up series is exactly one precharge-all, 8 auto refreshes and one mode load, with NOP on every cycle in between. Precharge to first refresh is T_RP cycles, and each later command follows the previous refresh by T_RC cycles. Command codes on {cs_n,ras_n,cas_n,we_n} are NOP 0111, precharge 0010, refresh 0001, mode load 0000.
- R4: During precharge-all the address bus is 0x400 (bit 10 set). During mode load it carries the mode word: burst length 1 (bits 2:0 = 000), sequential type (bit 3 = 0), latency field bits 6:4 = CLT code + 1, single-location write (bit 9 = 1), other bits 0. The default CLT gives 0x220.
- R5: The active flag (control bit 7, read-only) rises exactly T_MRD cycles after the mode load. ready is 1 only while the flag is set, the block is in READY and no sleep is requested.
- R6: The CAS latency field (bits 5:4) resets to 01 and is writable until the mode load. From the mode-load cycle on, writes to it are ignored.
- R7: The RAS-to-CAS delay field (bits 3:2, 00..11 meaning 1..4 cycles) resets to 01, can always be written and reads back as written.
- R8: Setting control bit 1 (sleep) drops ready at once. No command is issued while acc_busy stays high. One cycle after acc_busy falls, precharge-all is issued, then the refresh follows T_RP cycles later, with sd_cke falling in that same cycle.
- R9: sd_cke stays low while the sleep bit is set. After the bit clears, sd_cke rises on the second cycle. ready returns T_XSR cycles after sd_cke rises, and no command is issued in between.
- R10: Register read-back is {act, 0, clt, rcd, sleep, arm}, reset value 0x14. A write updates bits 1:0 and 3:2, and bits 5:4 unless locked. Bits 7:6 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| mem_wr | input | 1 | Write to SDRAM space seen (dummy write trigger) |
| acc_busy | input | 1 | Normal access path busy |
| ready | output | 1 | Normal accesses may be issued |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | SDRAM chip select |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_addr | output | ADDR_W | SDRAM address bus, carries the mode word |

## Verification
The hardest cases sit at the edges of the power-up wait and on the lock of the latency field. A dummy write must be refused in the very last wait cycle and accepted one cycle later. The bench counts cycles from reset release and places the armed dummy write exactly in that final cycle. It then confirms, through the scoreboard, that no command follows. It writes the latency field after bring-up and reads back the old value. Sleep entry is held off by keeping acc_busy high across the request, so the wait for the drain is exercised before the sleep series is expected.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        S_PWRUP, S_IDLE, S_PRE, S_PRE_WAIT, S_REF, S_REF_WAIT, S_LMR, S_LMR_WAIT,
        S_READY, S_DRAIN, S_SLP_PRE, S_SLP_GAP, S_SLP_REF, S_SLEEP, S_WAKE, S_SPARE
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_LMR = 4'b0000;

endpackage

// File: rtl/sdr_delay.sv
module sdr_delay #(
    parameter int W    = 16,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= W'(INIT);
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sdr_ctl_reg.sv
module sdr_ctl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       lock_set,
    input  logic       act_set,
    output logic       arm,
    output logic       sleep_req,
    output logic [1:0] clt,
    output logic       act,
    output logic [7:0] rdata
);
    logic [1:0] rcd;
    logic       locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm       <= 1'b0;
            sleep_req <= 1'b0;
            rcd       <= 2'b01;
            clt       <= 2'b01;
            act       <= 1'b0;
            locked    <= 1'b0;
        end else begin
            if (lock_set) locked <= 1'b1;
            if (act_set)  act    <= 1'b1;
            if (wr) begin
                arm       <= wdata[0];
                sleep_req <= wdata[1];
                rcd       <= wdata[3:2];
                if (!(locked || lock_set)) clt <= wdata[5:4];
            end
        end
    end

    assign rdata = {act, 1'b0, clt, rcd, sleep_req, arm};

    // R6: latency field frozen once the mode word has gone out
    a_r6_clt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr) |=> $stable(clt));

    // R5: active flag never falls back
    a_r5_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> act);

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
    import sdram_seq_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int PWRUP_US = 100,
    parameter int T_RP     = 3,
    parameter int T_RC     = 7,
    parameter int T_MRD    = 2,
    parameter int T_XSR    = 10,
    parameter int N_REF    = 8,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              mem_wr,
    input  logic              acc_busy,
    output logic              ready,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
    localparam int M1        = (T_RC > T_XSR) ? T_RC : T_XSR;
    localparam int MAXV      = (PWRUP_CYC > M1) ? PWRUP_CYC : M1;
    localparam int TW        = $clog2(MAXV + 1);
    localparam int RW        = $clog2(N_REF + 1);

    seq_state_t      state, state_n;
    logic [RW-1:0]   ref_cnt;
    logic            t_load, t_zero;
    logic [TW-1:0]   t_val;
    logic            arm, sleep_req, act;
    logic [1:0]      clt;
    logic [3:0]      cmd;
    logic [ADDR_W-1:0] mode_word;

    sdr_ctl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .lock_set(state == S_LMR), .act_set((state == S_LMR_WAIT) && t_zero),
        .arm(arm), .sleep_req(sleep_req), .clt(clt), .act(act), .rdata(reg_rdata)
    );

    sdr_delay #(.W(TW), .INIT(PWRUP_CYC - 1)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    always_comb begin
        mode_word      = '0;
        mode_word[6:4] = {1'b0, clt} + 3'd1;
        mode_word[9]   = 1'b1;
    end

    // state register and refresh counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_PWRUP;
            ref_cnt <= '0;
        end else begin
            state <= state_n;
            if (state == S_PRE)      ref_cnt <= '0;
            else if (state == S_REF) ref_cnt <= ref_cnt + 1'b1;
        end
    end

    // next state and delay loads
    always_comb begin
        state_n = state;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state)
            S_PWRUP:    if (t_zero) state_n = S_IDLE;
            S_IDLE:     if (arm && mem_wr) state_n = S_PRE;
            S_PRE: begin
                t_load = 1'b1; t_val = TW'(T_RP - 2); state_n = S_PRE_WAIT;
            end
            S_PRE_WAIT: if (t_zero) state_n = S_REF;
            S_REF: begin
                t_load = 1'b1; t_val = TW'(T_RC - 2); state_n = S_REF_WAIT;
            end
            S_REF_WAIT: if (t_zero) state_n = (ref_cnt == RW'(N_REF)) ? S_LMR : S_REF;
            S_LMR: begin
                t_load = 1'b1; t_val = TW'(T_MRD - 2); state_n = S_LMR_WAIT;
            end
            S_LMR_WAIT: if (t_zero) state_n = S_READY;
            S_READY:    if (sleep_req) state_n = S_DRAIN;
            S_DRAIN:    if (!acc_busy) state_n = S_SLP_PRE;
            S_SLP_PRE: begin
                t_load = 1'b1; t_val = TW'(T_RP - 2); state_n = S_SLP_GAP;
            end
            S_SLP_GAP:  if (t_zero) state_n = S_SLP_REF;
            S_SLP_REF:  state_n = S_SLEEP;
            S_SLEEP: if (!sleep_req) begin
                t_load = 1'b1; t_val = TW'(T_XSR - 1); state_n = S_WAKE;
            end
            S_WAKE:     if (t_zero) state_n = S_READY;
            S_SPARE:    state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd     = CMD_NOP;
        sd_cke  = 1'b1;
        sd_addr = '0;
        unique case (state)
            S_PRE, S_SLP_PRE: begin cmd = CMD_PRE; sd_addr[10] = 1'b1; end
            S_REF:            cmd = CMD_REF;
            S_LMR:            begin cmd = CMD_LMR; sd_addr = mode_word; end
            S_SLP_REF:        begin cmd = CMD_REF; sd_cke = 1'b0; end
            S_SLEEP:          sd_cke = 1'b0;
            default:          ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign ready = (state == S_READY) && act && !sleep_req;

    // checker: cycles since reset, saturating at the power-up length
    logic [TW-1:0] chk_cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        chk_cyc <= '0;
        else if (chk_cyc != TW'(PWRUP_CYC)) chk_cyc <= chk_cyc + 1'b1;
    end

    // R1: quiet command bus during power-up
    a_r1_quiet_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_cyc < TW'(PWRUP_CYC)) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));

    // R3: a command is always followed by a NOP
    a_r3_nop_between: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != CMD_NOP) |=>
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP));

    // R5: ready never without the active flag
    a_r5_ready_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> act);

    // R8: a precharge after bring-up only once the access path went idle
    a_r8_drain_first: assert property (@(posedge clk) disable iff (!rst_n)
        (act && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_PRE) |-> $past(!acc_busy));

    // R8: clock enable falls only together with a refresh command
    a_r8_cke_with_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_cke) |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_REF));

endmodule

// File: tb/test_sdram_seq.sv
`timescale 1ns/1ps
module test_sdram_seq;
    localparam int PWRUP = 25000;
    localparam int T_RP  = 3;
    localparam int T_RC  = 7;
    localparam int T_MRD = 2;
    localparam int T_XSR = 10;
    localparam int NREF  = 8;

    typedef struct {
        logic [3:0]  code;
        int          delta;
        logic [11:0] addr;
        bit          chk_addr;
        logic        cke;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic mem_wr = 1'b0;
    logic acc_busy = 1'b0;
    logic ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_addr;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_evt = 0;
    int wcyc = 0;
    int mark = 0;
    exp_t sb[$];
    exp_t e;

    sdram_seq #(.CLK_MHZ(250), .PWRUP_US(100), .T_RP(T_RP), .T_RC(T_RC),
                .T_MRD(T_MRD), .T_XSR(T_XSR), .N_REF(NREF), .ADDR_W(12)) i_sdram_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_wr(mem_wr), .acc_busy(acc_busy), .ready(ready),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wreg(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d; wcyc = cyc;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic dummy_write();
        @(negedge clk);
        mem_wr = 1'b1; mark = cyc; last_evt = cyc;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push(input logic [3:0] code, input int delta, input logic [11:0] addr,
                        input bit ca, input logic cke, input string req);
        exp_t x;
        x.code = code; x.delta = delta; x.addr = addr; x.chk_addr = ca; x.cke = cke; x.req = req;
        sb.push_back(x);
    endtask

    // monitor: every non-NOP command is matched against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} !== 4'b0111)) begin
            if (sb.size() == 0) begin
                chk("R1/R2 unexpected command", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
            end else begin
                e = sb.pop_front();
                chk({e.req, " code"}, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, e.code});
                chk({e.req, " spacing"}, cyc - last_evt, e.delta);
                if (e.chk_addr) chk({e.req, " address"}, {20'd0, sd_addr}, {20'd0, e.addr});
                chk({e.req, " cke"}, {31'd0, sd_cke}, {31'd0, e.cke});
                last_evt = cyc;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog (R1..): run did not complete");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lmr;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        chk("R10 reset readback", {24'd0, reg_rdata}, 32'h14);
        chk("R9 reset cke", {31'd0, sd_cke}, 32'd1);
        chk("R5 reset ready", {31'd0, ready}, 32'd0);

        // R6 / R7 writable before lock
        wreg(8'hF4);
        chk("R6 R10 clt writable, bits 7:6 ignore writes", {24'd0, reg_rdata}, 32'h34);
        wreg(8'h19);
        chk("R7 rcd readback", {24'd0, reg_rdata}, 32'h19);

        // R1: armed dummy write in the last power-up cycle is ignored
        wait_to(PWRUP - 2);
        dummy_write();
        chk("R1 dummy write at last wait cycle", mark, PWRUP - 1);
        repeat (30) @(negedge clk);
        chk("R1 no start from power-up", {31'd0, reg_rdata[7]}, 32'd0);

        // R2: unarmed dummy write ignored
        wreg(8'h18);
        dummy_write();
        repeat (40) @(negedge clk);
        chk("R2 unarmed write leaves act clear", {31'd0, reg_rdata[7]}, 32'd0);
        chk("R2 unarmed no ready", {31'd0, ready}, 32'd0);

        // R3 R4: bring-up series
        wreg(8'h19);
        push(4'b0010, 1, 12'h400, 1'b1, 1'b1, "R3 R4 precharge-all");
        for (int i = 0; i < NREF; i++)
            push(4'b0001, (i == 0) ? T_RP : T_RC, 12'h000, 1'b0, 1'b1, "R3 refresh");
        push(4'b0000, T_RC, 12'h220, 1'b1, 1'b1, "R3 R4 mode load");
        dummy_write();
        lmr = mark + 1 + T_RP + NREF * T_RC;
        wait_to(lmr);
        chk("R5 act clear at mode load", {31'd0, reg_rdata[7]}, 32'd0);
        wait_to(lmr + T_MRD - 1);
        chk("R5 ready not yet", {31'd0, ready}, 32'd0);
        wait_to(lmr + T_MRD);
        chk("R5 act set", {31'd0, reg_rdata[7]}, 32'd1);
        chk("R5 ready set", {31'd0, ready}, 32'd1);
        chk("R3 scoreboard drained", sb.size(), 0);

        // R6 lock, R7 still writable
        wreg(8'h2D);
        chk("R6 R7 clt locked, rcd written", {24'd0, reg_rdata}, 32'h9D);

        // R8 sleep entry held off by busy
        acc_busy = 1'b1;
        wreg(8'h2F);
        chk("R8 ready drops on sleep request", {31'd0, ready}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R8 cke high while draining", {31'd0, sd_cke}, 32'd1);
        push(4'b0010, 1, 12'h400, 1'b1, 1'b1, "R8 sleep precharge");
        push(4'b0001, T_RP, 12'h000, 1'b0, 1'b0, "R8 self-refresh entry");
        acc_busy = 1'b0; last_evt = cyc;
        repeat (T_RP + 4) @(negedge clk);
        chk("R8 sleep series done", sb.size(), 0);
        repeat (30) @(negedge clk);
        chk("R9 cke low in sleep", {31'd0, sd_cke}, 32'd0);

        // R9 wake
        wreg(8'h2D);
        chk("R9 cke still low", {31'd0, sd_cke}, 32'd0);
        @(negedge clk);
        chk("R9 cke raised", {31'd0, sd_cke}, 32'd1);
        wait_to(wcyc + 1 + T_XSR);
        chk("R9 ready not before exit time", {31'd0, ready}, 32'd0);
        wait_to(wcyc + 2 + T_XSR);
        chk("R9 ready after exit time", {31'd0, ready}, 32'd1);
        repeat (5) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule